// File: doc/BRIEF.md
# Audio/Video Power Sequencer

This controller decides, cycle by cycle, which parts of a combined audio line driver and video driver are powered. It drives the enable of the audio charge pump and the video charge pump. It drives the high-impedance controls of the composite (SD) path and the component (HD) path. It tells a separate mute-ramp block whether the audio output should ramp towards sound or towards silence. Finally, it raises a flag once the audio amplifier is fully in service.

A chip-level power-down input overrides everything. The mute-release control comes from a hard-wired pin or from a register bit, and a select pin chooses between them. By default, audio is allowed only while a video signal is present. A bypass bit removes that dependence. The video-present flag comes from an asynchronous analog detector and is synchronised inside the block.

Audio power-up is a sequence. The charge pump is started and allowed to settle for a counted number of prescaled ticks. The wait is long when the start was caused by video arriving, and short otherwise. The ramp block is then asked to unmute, and the block reports audio active once the ramp says it has finished. Power-down runs the same steps in reverse: the ramp goes first, and the pump is released only after the ramp has completed.

Top module: `av_power_sequencer`

## Requirements
- R1: While `pdn_n` is 0, `acp_en`, `vcp_en`, `audio_active` and `ramp_req` are 0, and `sd_hiz` and `hd_hiz` are 1, whatever the register inputs hold.
- R2: The mute-release control is `reg_unmute` when `bus_sel` is 1 and `mute_pin` when `bus_sel` is 0. A value of 1 means release, and the unselected source has no effect.
- R3: With `reg_det_bypass` 0, audio reaches `audio_active`=1 only while synchronised video is present and mute is released. Loss of video takes audio back to fully off.
- R4: With `reg_det_bypass` 1, the audio state follows only the mute-release control, and video presence has no effect on it.
- R5: `sd_hiz` is 0 only when powered, video is present and `reg_sd_on` is 1. `hd_hiz` follows the same rule with `reg_hd_on`.
- R6: `vcp_en` is 1 exactly when powered, video is present and at least one of `reg_sd_on` and `reg_hd_on` is 1.
- R7: `video_raw` passes through two synchronising flops. A change is visible on the video outputs after the second rising clock edge, and not after the first.
- R8: A power-up whose request first appears in the same cycle as a synchronised rising edge of video, with bypass 0, holds `acp_en`=1 and `ramp_req`=0 for exactly LONG_TICKS*TICK_DIV cycles before `ramp_req` rises.
- R9: Any other power-up, such as a mute release with video already present or any start with bypass 1, holds that phase for exactly SHORT_TICKS*TICK_DIV cycles.
- R10: After the pump wait, `ramp_req` is 1 and `audio_active` becomes 1 only in the cycle after a `ramp_fin` pulse. Withdrawing the request during the ramp-up does not cut it short.
- R11: On power-down, `ramp_req` and `audio_active` fall together while `acp_en` stays 1. `acp_en` falls only in the cycle after a `ramp_fin` pulse.
- R12: Withdrawing the request during the pump wait turns `acp_en` off after the next clock edge, without any ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pdn_n | input | 1 | Chip power-down, 0 = everything off |
| bus_sel | input | 1 | 1 = register mute control, 0 = pin mute control |
| mute_pin | input | 1 | Hard-wired mute release, 1 = sound allowed |
| reg_unmute | input | 1 | Register mute release, 1 = sound allowed |
| reg_det_bypass | input | 1 | 1 = audio independent of video presence |
| reg_sd_on | input | 1 | Composite path enable |
| reg_hd_on | input | 1 | Component path enable |
| video_raw | input | 1 | Asynchronous video-present flag from the detector |
| ramp_fin | input | 1 | One-cycle pulse: mute ramp has reached its target |
| acp_en | output | 1 | Audio charge pump enable |
| vcp_en | output | 1 | Video charge pump enable |
| audio_active | output | 1 | Audio amplifier fully in service |
| ramp_req | output | 1 | Ramp target, 1 = unmuted, 0 = muted |
| sd_hiz | output | 1 | Composite output high impedance |
| hd_hiz | output | 1 | Component outputs high impedance |

## Verification
The risky overlap is a mute release that lands in the very cycle in which the synchronised video edge appears. Two functions meet in that cycle: the edge detector that picks the long wait, and the mute selector that raises the request. The bench lets `video_raw` rise and then releases mute after two edges, which is the edge-detect cycle. It repeats the sequence with the release one edge later. It counts the sampled cycles with the pump on and the ramp not yet requested, and expects the long count in the first case and the short count in the second.

// File: rtl/avps_pkg.sv
package avps_pkg;
   typedef enum logic [2:0] {
      AU_OFF  = 3'd0,
      AU_PUMP = 3'd1,
      AU_RISE = 3'd2,
      AU_ON   = 3'd3,
      AU_FALL = 3'd4
   } au_state_t;
endpackage

// File: rtl/avps_sync.sv
module avps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/avps_tick.sv
module avps_tick #(
   parameter int DIV = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = run;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (!run)         cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/avps_audio_fsm.sv
module avps_audio_fsm
   import avps_pkg::*;
#(
   parameter int LONG_TICKS  = 225,
   parameter int SHORT_TICKS = 50,
   parameter int WAIT_W      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdn_n,
   input  logic want,
   input  logic long_sel,
   input  logic tick,
   input  logic ramp_fin,
   output logic pump_run,
   output logic pump_on,
   output logic ramp_up,
   output logic in_service
);
   au_state_t         st;
   logic [WAIT_W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= AU_OFF;
         left <= '0;
      end else if (!pdn_n) begin
         st   <= AU_OFF;
         left <= '0;
      end else begin
         case (st)
            AU_OFF: if (want) begin
               st   <= AU_PUMP;
               left <= long_sel ? WAIT_W'(LONG_TICKS) : WAIT_W'(SHORT_TICKS);
            end
            AU_PUMP: begin
               if (!want) st <= AU_OFF;
               else if (tick) begin
                  if (left == WAIT_W'(1)) st <= AU_RISE;
                  left <= left - 1'b1;
               end
            end
            AU_RISE: if (ramp_fin) st <= AU_ON;
            AU_ON:   if (!want)    st <= AU_FALL;
            AU_FALL: if (ramp_fin) st <= AU_OFF;
            default: st <= AU_OFF;
         endcase
      end
   end

   assign pump_run   = (st == AU_PUMP);
   assign pump_on    = (st != AU_OFF);
   assign ramp_up    = (st == AU_RISE) || (st == AU_ON);
   assign in_service = (st == AU_ON);
endmodule

// File: rtl/av_power_sequencer.sv
module av_power_sequencer #(
   parameter int TICK_DIV    = 1000,
   parameter int LONG_TICKS  = 225,
   parameter int SHORT_TICKS = 50,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdn_n,
   input  logic bus_sel,
   input  logic mute_pin,
   input  logic reg_unmute,
   input  logic reg_det_bypass,
   input  logic reg_sd_on,
   input  logic reg_hd_on,
   input  logic video_raw,
   input  logic ramp_fin,
   output logic acp_en,
   output logic vcp_en,
   output logic audio_active,
   output logic ramp_req,
   output logic sd_hiz,
   output logic hd_hiz
);
   localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
   localparam int WAIT_W    = $clog2(MAX_TICKS + 1);

   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (SHORT_TICKS < 1 || LONG_TICKS < 1) begin : g_bad_wait
      $error("wait lengths must be at least one tick");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic vid_s, vid_prev, vid_rise, vid_live;
   logic mute_rel, want, long_sel, tick;
   logic pump_run, pump_on, ramp_up, in_service;

   avps_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(video_raw), .q(vid_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vid_prev <= 1'b0;
      else        vid_prev <= vid_s;
   end

   assign vid_rise = vid_s && !vid_prev;
   assign vid_live = pdn_n && vid_s;
   assign mute_rel = bus_sel ? reg_unmute : mute_pin;
   assign want     = pdn_n && mute_rel && (reg_det_bypass || vid_s);
   assign long_sel = !reg_det_bypass && vid_rise;

   avps_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(pump_run), .tick(tick)
   );

   avps_audio_fsm #(
      .LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS), .WAIT_W(WAIT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .want(want),
      .long_sel(long_sel), .tick(tick), .ramp_fin(ramp_fin),
      .pump_run(pump_run), .pump_on(pump_on), .ramp_up(ramp_up),
      .in_service(in_service)
   );

   assign acp_en       = pdn_n && pump_on;
   assign ramp_req     = pdn_n && ramp_up;
   assign audio_active = pdn_n && in_service;
   assign sd_hiz       = !(vid_live && reg_sd_on);
   assign hd_hiz       = !(vid_live && reg_hd_on);
   assign vcp_en       = vid_live && (reg_sd_on || reg_hd_on);
endmodule

// File: rtl/avps_chk.sv
module avps_chk (
   input logic clk,
   input logic rst_n,
   input logic pdn_n,
   input logic ramp_fin,
   input logic acp_en,
   input logic vcp_en,
   input logic audio_active,
   input logic ramp_req,
   input logic sd_hiz,
   input logic hd_hiz
);
   // R1
   pdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_n |-> (!acp_en && !vcp_en && !audio_active && !ramp_req && sd_hiz && hd_hiz));

   // R6
   vcp_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vcp_en == (!sd_hiz || !hd_hiz));

   // R8
   pump_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acp_en) |-> !ramp_req);

   // R9
   wait_before_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ramp_req) && pdn_n) |-> $past(acp_en));

   // R10
   active_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(audio_active) |-> $past(ramp_fin));

   // R10
   active_needs_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      audio_active |-> (ramp_req && acp_en));

   // R11
   pump_held_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ramp_req) && pdn_n) |-> acp_en);
endmodule

bind av_power_sequencer avps_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .ramp_fin(ramp_fin),
   .acp_en(acp_en), .vcp_en(vcp_en), .audio_active(audio_active),
   .ramp_req(ramp_req), .sd_hiz(sd_hiz), .hd_hiz(hd_hiz)
);

// File: tb/tb_av_power_sequencer.sv
module tb_av_power_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int DIV   = 4;
   localparam int LONGT = 9;
   localparam int SHORTT = 3;
   localparam int RAMP  = 3;
   localparam int SETTLE = 80;
   localparam int NVEC  = 10;

   // [11]pdn [10]bus [9]pin [8]unmute [7]bypass [6]sd [5]hd [4]vid
   // [3]exp sd_hiz [2]exp hd_hiz [1]exp vcp_en [0]exp audio_active
   localparam logic [11:0] VEC [NVEC] = '{
      12'b0111_1111_1100,
      12'b1101_0111_0011,
      12'b1101_0110_1100,
      12'b1101_1110_1101,
      12'b1110_1110_1100,
      12'b1010_0101_0111,
      12'b1001_0011_1010,
      12'b1101_0001_1101,
      12'b0011_1111_1100,
      12'b1101_1111_0011
   };

   logic clk = 1'b0;
   logic rst_n, pdn_n, bus_sel, mute_pin, reg_unmute, reg_det_bypass;
   logic reg_sd_on, reg_hd_on, video_raw, ramp_fin;
   logic acp_en, vcp_en, audio_active, ramp_req, sd_hiz, hd_hiz;
   logic ramp_auto = 1'b1;
   logic last_req = 1'b0;
   int   rcnt = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   int   cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   av_power_sequencer #(
      .TICK_DIV(DIV), .LONG_TICKS(LONGT), .SHORT_TICKS(SHORTT), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .bus_sel(bus_sel),
      .mute_pin(mute_pin), .reg_unmute(reg_unmute),
      .reg_det_bypass(reg_det_bypass), .reg_sd_on(reg_sd_on),
      .reg_hd_on(reg_hd_on), .video_raw(video_raw), .ramp_fin(ramp_fin),
      .acp_en(acp_en), .vcp_en(vcp_en), .audio_active(audio_active),
      .ramp_req(ramp_req), .sd_hiz(sd_hiz), .hd_hiz(hd_hiz)
   );

   // mute ramp model: pulse ramp_fin RAMP cycles after each change of ramp_req
   always @(negedge clk) begin
      if (!ramp_auto) begin
         last_req = ramp_req;
         rcnt = 0;
      end else begin
         ramp_fin = 1'b0;
         if (ramp_req !== last_req) begin
            last_req = ramp_req;
            rcnt = RAMP;
         end else if (rcnt > 0) begin
            rcnt = rcnt - 1;
            if (rcnt == 0) ramp_fin = 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic chk_n(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic meas(output int c);
      c = 0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         #1;
         if (ramp_req) break;
         if (acp_en) c++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog (all requirements): run still busy, got >150000 cycles expected fewer");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 0; pdn_n = 0; bus_sel = 1; mute_pin = 0; reg_unmute = 0;
      reg_det_bypass = 0; reg_sd_on = 1; reg_hd_on = 1; video_raw = 0;
      ramp_fin = 0;
      step(3);
      rst_n = 1;
      step(2);
      // R1 reset state with power-down held
      chk("R1 reset acp_en", acp_en, 1'b0);
      chk("R1 reset vcp_en", vcp_en, 1'b0);
      chk("R1 reset sd_hiz", sd_hiz, 1'b1);
      chk("R1 reset ramp_req", ramp_req, 1'b0);

      // table walk: settled states
      for (int i = 0; i < NVEC; i++) begin
         logic [11:0] v;
         string atag;
         v = VEC[i];
         pdn_n = v[11]; bus_sel = v[10]; mute_pin = v[9]; reg_unmute = v[8];
         reg_det_bypass = v[7]; reg_sd_on = v[6]; reg_hd_on = v[5]; video_raw = v[4];
         step(SETTLE);
         if (!v[11])     atag = "R1 audio_active";
         else if (v[7])  atag = "R4 audio_active";
         else if (!v[10]) atag = "R2 audio_active";
         else            atag = "R3 audio_active";
         chk(v[11] ? "R5 sd_hiz" : "R1 sd_hiz", sd_hiz, v[3]);
         chk(v[11] ? "R5 hd_hiz" : "R1 hd_hiz", hd_hiz, v[2]);
         chk(v[11] ? "R6 vcp_en" : "R1 vcp_en", vcp_en, v[1]);
         chk(atag, audio_active, v[0]);
      end

      // R7: two-flop synchroniser latency
      pdn_n = 1; bus_sel = 1; reg_unmute = 0; reg_det_bypass = 0;
      reg_sd_on = 1; reg_hd_on = 0; video_raw = 0;
      step(SETTLE);
      video_raw = 1;
      step(1);
      chk("R7 sd_hiz after one edge", sd_hiz, 1'b1);
      step(1);
      chk("R7 sd_hiz after two edges", sd_hiz, 1'b0);

      // R8: video arrival with mute already released -> long wait
      video_raw = 0; reg_unmute = 1; reg_hd_on = 1;
      step(SETTLE);
      chk("R3 no video keeps audio off", acp_en, 1'b0);
      video_raw = 1;
      meas(cnt);
      chk_n("R8 long pump wait", cnt, LONGT * DIV);
      step(RAMP + 3);
      chk("R10 active after ramp", audio_active, 1'b1);

      // R8 corner: release in the very cycle the synchronised edge appears
      reg_unmute = 0; video_raw = 0;
      step(SETTLE);
      video_raw = 1;
      step(2);
      reg_unmute = 1;
      meas(cnt);
      chk_n("R8 coincident release long wait", cnt, LONGT * DIV);

      // R9 corner: release one cycle after the edge -> short wait
      reg_unmute = 0; video_raw = 0;
      step(SETTLE);
      video_raw = 1;
      step(3);
      reg_unmute = 1;
      meas(cnt);
      chk_n("R9 late release short wait", cnt, SHORTT * DIV);

      // R9: bypass set, no video
      reg_unmute = 0; video_raw = 0; reg_det_bypass = 1;
      step(SETTLE);
      reg_unmute = 1;
      meas(cnt);
      chk_n("R9 bypass short wait", cnt, SHORTT * DIV);
      reg_det_bypass = 0;

      // R12: withdraw during pump wait
      reg_unmute = 0; video_raw = 1;
      step(SETTLE);
      reg_unmute = 1;
      step(3);
      chk("R12 pump started", acp_en, 1'b1);
      reg_unmute = 0;
      step(1);
      chk("R12 pump off after withdraw", acp_en, 1'b0);
      chk("R12 no ramp after withdraw", ramp_req, 1'b0);

      // R10/R11 with manual ramp completion
      step(SETTLE);
      ramp_auto = 0;
      ramp_fin = 0;
      reg_unmute = 1;
      meas(cnt);
      chk_n("R9 release with video present", cnt, SHORTT * DIV);
      reg_unmute = 0;
      step(5);
      chk("R10 ramp-up not cancelled", ramp_req, 1'b1);
      chk("R10 not active before ramp_fin", audio_active, 1'b0);
      ramp_fin = 1;
      step(1);
      ramp_fin = 0;
      chk("R10 active after ramp_fin", audio_active, 1'b1);
      step(1);
      chk("R11 ramp_req drops", ramp_req, 1'b0);
      chk("R11 audio_active drops", audio_active, 1'b0);
      chk("R11 pump held during ramp-down", acp_en, 1'b1);
      step(4);
      chk("R11 pump still held", acp_en, 1'b1);
      ramp_fin = 1;
      step(1);
      ramp_fin = 0;
      chk("R11 pump off after ramp_fin", acp_en, 1'b0);
      ramp_auto = 1;

      // R1: power-down mid-service
      reg_unmute = 1;
      step(SETTLE);
      chk("R3 audio back on", audio_active, 1'b1);
      pdn_n = 0;
      #1;
      chk("R1 pdn forces pump off", acp_en, 1'b0);
      chk("R1 pdn forces audio off", audio_active, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule